// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial master read and write a bank of 8-bit registers. The master lowers the active-low select line, shifts in a 16-bit instruction word and then moves one to eight data bytes. Every bit is taken on the rising edge of the serial clock, and every read bit is launched on its falling edge. The instruction holds a write flag, a byte count and a 10-bit start address. Each later byte in the same transfer goes to the next lower address.

The serial clock, select and data input are oversampled by the system clock through a short synchronizer. A state machine then follows the transfer and has five states. `ST_IDLE` means not selected. `ST_INSTR` shifts the instruction. `ST_WDATA` and `ST_RDATA` carry the data bytes. `ST_DONE` means the byte count is used up and further clocks are ignored. The transitions are:
- `ST_IDLE` goes to `ST_INSTR` when select is seen low.
- `ST_INSTR` goes to `ST_WDATA` or `ST_RDATA` on the 16th rising edge, according to the write flag.
- Either data state goes to `ST_DONE` on the last bit of the last byte.
- Any state returns to `ST_IDLE` when select is seen high.

Two wiring modes exist. In 4-wire mode, read data leaves on a dedicated output. In 3-wire mode, the single data line is shared: the block drives it only while it returns read bytes. A side read-back port shows any register directly.

Top module: `spi_regslave`

## Requirements
- R1: After reset every register reads 0x00, and both output enables are low.
- R2: The instruction is shifted MSB first. Bit 15 selects the direction (1 = write, 0 = read). Bits [14:12] hold the byte count minus one, so 1 to 8 bytes. Bits [9:0] give the start address. Bits [11:10] have no effect on the transfer.
- R3: Write bytes are shifted MSB first. A byte is stored only after its eighth bit. Byte k of a transfer goes to the start address minus k, modulo 1024.
- R4: Read bytes come from the same address sequence, MSB first. Each bit changes only after a falling edge of the serial clock. The first bit is driven after the falling edge that follows the 16th instruction bit.
- R5: Exactly the number of bytes in the count is transferred. Clocks after that, while still selected, change no register.
- R6: If select rises mid-transfer, the bytes already completed stay written and a partially shifted byte is discarded. This includes an abort during the instruction.
- R7: Addresses at or above NUM_REGS ignore writes and read as 0x00, both serially and on the read-back port.
- R8: In 4-wire mode, read data appears on `sdo` and `sdo_oe` is high while selected. `sdio_oe` stays low.
- R9: In 3-wire mode, read data appears on `sdio_out`, and `sdio_oe` is high only during the read data phase. `sdo_oe` stays low.
- R10: Once select has been high for a few system clocks, both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| three_wire | input | 1 | 1 selects the shared-line mode; change it only while deselected |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data input (the shared line's input in 3-wire mode) |
| sdo | output | 1 | 4-wire read data |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| sdio_out | output | 1 | 3-wire read data toward the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| rb_addr | input | 10 | Read-back address |
| rb_data | output | 8 | Read-back register value, 0x00 when out of range |

## Verification
The hardest case to reach is select rising part way through a byte, at an exact bit position inside the instruction or inside a data byte. The stimulus task therefore counts every clocked bit and drops select once a chosen count is reached. The bench then inspects the neighbouring registers through the read-back port to confirm that only whole bytes landed. Address wrap below zero, counts longer than the clocks sent, clocks beyond the count, and the 3-wire turnaround are directed. Random transfers of mixed direction, length, mode and address are checked against a bench register model.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

    localparam int ADDR_W     = 10;
    localparam int BYTE_W     = 8;
    localparam int LEN_W      = 3;
    localparam int INSTR_BITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } xfer_state_t;

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_hi,
    output logic sdi_s
);
    logic [STAGES-1:0] sclk_ch;
    logic [STAGES-1:0] cs_ch;
    logic [STAGES-1:0] sdi_ch;
    logic              sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_ch   <= '0;
            cs_ch     <= '1;
            sdi_ch    <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_ch   <= {sclk_ch[STAGES-2:0], sclk};
            cs_ch     <= {cs_ch[STAGES-2:0], cs_n};
            sdi_ch    <= {sdi_ch[STAGES-2:0], sdi};
            sclk_prev <= sclk_ch[STAGES-1];
        end
    end

    assign sclk_rise = sclk_ch[STAGES-1] & ~sclk_prev;
    assign sclk_fall = ~sclk_ch[STAGES-1] & sclk_prev;
    assign cs_hi     = cs_ch[STAGES-1];
    assign sdi_s     = sdi_ch[STAGES-1];

endmodule

// File: rtl/spi_rs_regfile.sv
module spi_rs_regfile
    import spi_rs_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int RD_PORTS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                waddr,
    input  logic [BYTE_W-1:0]                wdata,
    input  logic [RD_PORTS-1:0][ADDR_W-1:0]  raddr,
    output logic [RD_PORTS-1:0][BYTE_W-1:0]  rdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic [BYTE_W-1:0] mem [NUM_REGS];

    function automatic logic in_range(input logic [ADDR_W-1:0] a);
        return {1'b0, a} < LIMIT;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (we && in_range(waddr)) begin
            mem[waddr[IDX_W-1:0]] <= wdata;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = in_range(raddr[p]) ? mem[raddr[p][IDX_W-1:0]] : '0;
    end

endmodule

// File: rtl/spi_rs_ctrl.sv
module spi_rs_ctrl
    import spi_rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_hi,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo_bit,
    output logic              in_read,
    output logic              active
);
    // 13 kept instruction bits: direction, length, address[9:1]
    logic [12:0]       in_sh;
    logic [3:0]        bit_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [BYTE_W-1:0] rd_sh;
    logic              sdo_q;
    xfer_state_t       state_q;
    xfer_state_t       state_d;

    logic              instr_last;
    logic              byte_last;
    logic              spare_slot;
    logic              start_wr;
    logic [LEN_W-1:0]  start_len;
    logic [ADDR_W-1:0] start_addr;

    assign instr_last = sclk_rise && (bit_cnt == 4'(INSTR_BITS - 1));
    assign byte_last  = sclk_rise && (bit_cnt == 4'(BYTE_W - 1));
    // instruction bits 11 and 10 arrive at counts 4 and 5; they are dropped
    assign spare_slot = (bit_cnt == 4'd4) || (bit_cnt == 4'd5);
    assign start_wr   = in_sh[12];
    assign start_len  = in_sh[11:9];
    assign start_addr = {in_sh[8:0], sdi_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (cs_hi) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_INSTR;
                ST_INSTR: begin
                    if (instr_last) begin
                        state_d = start_wr ? ST_WDATA : ST_RDATA;
                    end
                end
                ST_WDATA,
                ST_RDATA: begin
                    if (byte_last && (left_q == '0)) begin
                        state_d = ST_DONE;
                    end
                end
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sh   <= '0;
            bit_cnt <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            rd_sh   <= '0;
            sdo_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt <= '0;
                end
                ST_INSTR: begin
                    if (sclk_rise) begin
                        if (instr_last) begin
                            bit_cnt <= '0;
                            addr_q  <= start_addr;
                            left_q  <= start_len;
                            if (!start_wr) begin
                                rd_sh <= rd_data;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 4'd1;
                            if (!spare_slot) begin
                                in_sh <= {in_sh[11:0], sdi_s};
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (sclk_rise) begin
                        in_sh <= {in_sh[11:0], sdi_s};
                        if (byte_last) begin
                            bit_cnt <= '0;
                            if (left_q != '0) begin
                                left_q <= left_q - 3'd1;
                                addr_q <= addr_q - 10'd1;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RDATA: begin
                    if (sclk_rise) begin
                        if (byte_last) begin
                            bit_cnt <= '0;
                            if (left_q != '0) begin
                                left_q <= left_q - 3'd1;
                                addr_q <= addr_q - 10'd1;
                                rd_sh  <= rd_data;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end else if (sclk_fall) begin
                        sdo_q <= rd_sh[BYTE_W-1];
                        rd_sh <= {rd_sh[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_DONE: begin
                    bit_cnt <= bit_cnt;
                end
                default: begin
                    bit_cnt <= '0;
                end
            endcase
        end
    end

    always_comb begin
        wr_en   = (state_q == ST_WDATA) && byte_last;
        wr_addr = addr_q;
        wr_data = {in_sh[6:0], sdi_s};
        rd_addr = (state_q == ST_INSTR) ? start_addr : (addr_q - 10'd1);
        in_read = (state_q == ST_RDATA);
        active  = (state_q != ST_IDLE);
        sdo_bit = sdo_q;
    end

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_rs_pkg::*;
#(
    parameter int NUM_REGS    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              three_wire,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sdio_out,
    output logic              sdio_oe,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [BYTE_W-1:0] rb_data
);
    logic                     sclk_rise;
    logic                     sclk_fall;
    logic                     cs_hi;
    logic                     sdi_s;
    logic                     rf_we;
    logic [ADDR_W-1:0]        rf_waddr;
    logic [BYTE_W-1:0]        rf_wdata;
    logic [ADDR_W-1:0]        core_raddr;
    logic [1:0][ADDR_W-1:0]   rf_raddr;
    logic [1:0][BYTE_W-1:0]   rf_rdata;
    logic                     sdo_bit;
    logic                     in_read;
    logic                     active;

    spi_rs_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_hi     (cs_hi),
        .sdi_s     (sdi_s)
    );

    spi_rs_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_hi     (cs_hi),
        .sdi_s     (sdi_s),
        .rd_data   (rf_rdata[0]),
        .rd_addr   (core_raddr),
        .wr_en     (rf_we),
        .wr_addr   (rf_waddr),
        .wr_data   (rf_wdata),
        .sdo_bit   (sdo_bit),
        .in_read   (in_read),
        .active    (active)
    );

    assign rf_raddr[0] = core_raddr;
    assign rf_raddr[1] = rb_addr;

    spi_rs_regfile #(.NUM_REGS(NUM_REGS), .RD_PORTS(2)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    assign rb_data  = rf_rdata[1];
    assign sdo      = sdo_bit;
    assign sdo_oe   = active & ~three_wire;
    assign sdio_out = sdo_bit;
    assign sdio_oe  = in_read & three_wire;

endmodule

// File: rtl/spi_rs_checker.sv
module spi_rs_checker
    import spi_rs_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdo_oe,
    input logic              sdio_oe,
    input logic              sdo_bit,
    input logic              sclk_fall,
    input logic              wr_en,
    input logic [ADDR_W-1:0] rb_addr,
    input logic [BYTE_W-1:0] rb_data
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!sdo_oe && !sdio_oe)); // R10

    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdo_oe, sdio_oe})); // R9

    AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_bit) |-> $past(sclk_fall)); // R4

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rb_addr) && !$past(wr_en)) |-> $stable(rb_data)); // R3

    AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rb_addr} >= LIMIT) |-> (rb_data == '0)); // R7

endmodule

bind spi_regslave spi_rs_checker #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo_oe    (sdo_oe),
    .sdio_oe   (sdio_oe),
    .sdo_bit   (sdo_bit),
    .sclk_fall (sclk_fall),
    .wr_en     (rf_we),
    .rb_addr   (rb_addr),
    .rb_data   (rb_data)
);

// File: tb/spi_regslave_tb_top.sv
module spi_regslave_tb_top;

    localparam int NREG = 64;
    localparam int HALF = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       three_wire = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo, sdo_oe, sdio_out, sdio_oe;
    logic [9:0] rb_addr = '0;
    logic [7:0] rb_data;

    int checks = 0;
    int failures = 0;

    logic [7:0] mdl [NREG];
    logic [7:0] tx  [8];
    logic [7:0] rx  [8];

    always #4 clk = ~clk;

    spi_regslave #(.NUM_REGS(NREG), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .three_wire(three_wire), .sclk(sclk),
        .cs_n(cs_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .rb_addr(rb_addr), .rb_data(rb_data)
    );

    function automatic logic [9:0] byte_addr(input logic [9:0] a, input int b);
        return 10'(a - 10'(b));
    endfunction

    function automatic logic [7:0] exp_reg(input logic [9:0] a);
        return (a < 10'(NREG)) ? mdl[a[5:0]] : 8'h00;
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp,
                         input string req, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic rb_check(input logic [9:0] a, input string req);
        rb_addr = a;
        @(negedge clk);
        check(32'(rb_data), 32'(exp_reg(a)), req, $sformatf("readback @%0h", a));
    endtask

    // len: count in instruction; nsend: bytes clocked; abort_at: bit count at which select rises
    task automatic spi_txn(input bit wr, input int len, input int nsend,
                           input logic [9:0] a, input logic [1:0] spare,
                           input int abort_at, input string req);
        logic [15:0] iw;
        int  sent;
        bit  stop;
        bit  oe_bad;
        int  full;
        iw = {wr, 3'(len - 1), spare, a};
        sent = 0; stop = 0; oe_bad = 0;
        cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < 16 && !stop; i++) begin
            if (sent == abort_at) stop = 1;
            else begin
                sdi = iw[15-i];
                #(HALF);
                if (sdio_oe) oe_bad = 1;
                sclk = 1'b1; #(HALF); sclk = 1'b0;
                sent++;
            end
        end
        for (int b = 0; b < nsend && !stop; b++) begin
            for (int k = 0; k < 8 && !stop; k++) begin
                if (sent == abort_at) stop = 1;
                else begin
                    if (wr) begin
                        sdi = tx[b][7-k];
                        #(HALF);
                        if (sdio_oe) oe_bad = 1;
                    end else begin
                        #(HALF);
                        rx[b][7-k] = three_wire ? sdio_out : sdo;
                        if (b < len) begin
                            if (three_wire && (!sdio_oe || sdo_oe)) oe_bad = 1;
                            if (!three_wire && (!sdo_oe || sdio_oe)) oe_bad = 1;
                        end
                    end
                    sclk = 1'b1; #(HALF); sclk = 1'b0;
                    sent++;
                end
            end
        end
        #(HALF);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check(32'({sdo_oe, sdio_oe}), 32'h0, "R10", "enables after deselect");
        check(32'(oe_bad), 32'h0, three_wire ? "R9" : "R8", "enable during transfer");
        if (wr) begin
            full = (sent >= 16) ? (sent - 16) / 8 : 0;
            if (full > len) full = len;
            for (int b = 0; b < full; b++) begin
                if (byte_addr(a, b) < 10'(NREG)) mdl[byte_addr(a, b)] = tx[b];
            end
        end
    endtask

    task automatic check_rx(input int len, input logic [9:0] a, input string req);
        for (int b = 0; b < len; b++) begin
            check(32'(rx[b]), 32'(exp_reg(byte_addr(a, b))), req,
                  $sformatf("serial read byte %0d from %0h", b, byte_addr(a, b)));
        end
    endtask

    initial begin
        #(1_500_000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check(32'({sdo_oe, sdio_oe}), 32'h0, "R1", "enables after reset");
        rb_check(10'h000, "R1");
        rb_check(10'h02A, "R1");
        rb_check(10'h03F, "R1");

        // R3 four-byte write from 0x02A, descending addresses
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h81; tx[3] = 8'h7E;
        spi_txn(1, 4, 4, 10'h02A, 2'b00, 1000, "R3");
        for (int b = 0; b < 4; b++) rb_check(byte_addr(10'h02A, b), "R3");
        rb_check(10'h026, "R5");

        // R4 / R8 read the same bytes back in 4-wire mode
        spi_txn(0, 4, 4, 10'h02A, 2'b00, 1000, "R4");
        check_rx(4, 10'h02A, "R4");

        // R2 spare bits ignored
        tx[0] = 8'hC3;
        spi_txn(1, 1, 1, 10'h010, 2'b11, 1000, "R2");
        rb_check(10'h010, "R2");
        spi_txn(0, 1, 1, 10'h010, 2'b10, 1000, "R2");
        check_rx(1, 10'h010, "R2");

        // R3 / R7 wrap below zero lands out of range
        tx[0] = 8'h5A; tx[1] = 8'hEE;
        spi_txn(1, 2, 2, 10'h000, 2'b00, 1000, "R3");
        rb_check(10'h000, "R3");
        rb_check(10'h03F, "R7");
        rb_check(10'h3FF, "R7");
        spi_txn(0, 2, 2, 10'h000, 2'b00, 1000, "R7");
        check_rx(2, 10'h000, "R7");

        // R7 out-of-range write does not alias
        tx[0] = 8'h99;
        spi_txn(1, 1, 1, 10'h050, 2'b00, 1000, "R7");
        rb_check(10'h010, "R7");
        rb_check(10'h050, "R7");

        // R6 abort in the middle of the second byte
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
        spi_txn(1, 3, 3, 10'h020, 2'b00, 16 + 8 + 5, "R6");
        rb_check(10'h020, "R6");
        rb_check(10'h01F, "R6");
        check(32'(rb_data), 32'h0, "R6", "partial byte discarded");

        // R6 abort during the instruction
        tx[0] = 8'hFF;
        spi_txn(1, 1, 1, 10'h01F, 2'b00, 10, "R6");
        rb_check(10'h01F, "R6");

        // R5 extra clocks after the count
        tx[0] = 8'h42; tx[1] = 8'hBD;
        spi_txn(1, 1, 2, 10'h030, 2'b00, 1000, "R5");
        rb_check(10'h030, "R5");
        rb_check(10'h02F, "R5");

        // R9 3-wire write and read
        three_wire = 1'b1;
        tx[0] = 8'h6D; tx[1] = 8'h90; tx[2] = 8'h01;
        spi_txn(1, 3, 3, 10'h00C, 2'b00, 1000, "R9");
        spi_txn(0, 3, 3, 10'h00C, 2'b00, 1000, "R9");
        check_rx(3, 10'h00C, "R9");
        three_wire = 1'b0;
        repeat (4) @(negedge clk);

        // random mix
        for (int n = 0; n < 30; n++) begin
            bit            wr;
            int            len;
            logic [9:0]    a;
            wr  = 1'($urandom % 2);
            len = 1 + int'($urandom % 8);
            a   = 10'($urandom % 72);
            three_wire = 1'($urandom % 2);
            repeat (4) @(negedge clk);
            for (int b = 0; b < 8; b++) tx[b] = 8'($urandom);
            spi_txn(wr, len, len, a, 2'($urandom), 1000, wr ? "R3" : "R4");
            if (!wr) check_rx(len, a, "R4");
        end
        three_wire = 1'b0;

        for (int i = 0; i < NREG; i++) rb_check(10'(i), "R3");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule